// File: doc/BRIEF.md
# Double-to-Single Precision Rounding Converter

This block narrows a 64-bit IEEE 754 binary64 operand to a 32-bit binary32 result in one clock. On every rising edge it captures the operand and a 2-bit rounding-mode select. The register output then holds the converted value and three sticky-free status flags: overflow, underflow and inexact. It handles every class of input. Signed zeros, infinities and NaNs pass through their own paths. Finite values are re-biased and their significand is cut to 23 fraction bits with guard and sticky information. Results below the smallest normal single are built as gradual-underflow subnormals rather than flushed.

Each input is sorted into one of five operand classes: ZERO, TINY (a binary64 subnormal), FINITE, INF and NAN. The output process picks the result path with a unique case on that class. There is no state held from one conversion to the next. Each clock is a fresh transition from whatever class was seen last to the class of the current operand. The result always appears exactly one edge after the operand is presented. Reset (asynchronous, active low) forces the result and all flags to zero.

Top module: `d2s_converter`

## Requirements
- R1: The result and flags are registered and appear one clock after the operand. While reset is low, `sgl_out` and all three flags are zero.
- R2: For a finite input whose rounded value lies within the normal single range, the output is laid out as follows: the sign goes in bit 31, the biased exponent in bits 30..23 and the fraction in bits 22..0. The single biased exponent equals the double biased exponent minus 896, and the fraction is the top 23 input fraction bits after rounding.
- R3: A finite result whose unrounded magnitude is below 2^-126 is encoded as a subnormal, with exponent field 0 and fraction equal to the magnitude divided by 2^-149, rounded. 2^-149 gives 0x00000001, and rounding that reaches 2^-126 gives exponent field 1 and fraction 0.
- R4: A signed zero input gives a zero of the same sign with no flags. A nonzero binary64 subnormal input is treated as a positive-width value far below 2^-149, so the result is zero or the smallest subnormal depending on the mode.
- R5: An infinite input gives an infinity of the same sign (0x7F800000 or 0xFF800000) with no flags.
- R6: A NaN input gives a quiet NaN with the same sign, exponent field 255 and fraction bit 22 set, followed by input fraction bits 51..30. No flags are raised.
- R7: When the rounded magnitude is 2^128 or more, overflow and inexact are raised. The result is infinity if the mode rounds away from zero for that sign, and 0x7F7FFFFF with the input sign otherwise.
- R8: `rnd_mode` 00 selects round to nearest with ties to even. A tie (the guard bit 1 and every lower discarded bit 0) goes to the neighbour whose fraction LSB is 0.
- R9: `rnd_mode` 01 rounds toward zero, 10 toward +infinity and 11 toward -infinity. Any nonzero discarded bit counts for the two directed modes.
- R10: Inexact is raised exactly when a discarded bit is nonzero or overflow occurs.
- R11: Underflow is raised exactly when the unrounded magnitude is below 2^-126 and the result is inexact.
- R12: A round-up carry out of the fraction increments the exponent field. For example, 1.11..1 (23 ones) with the guard bit set, rounded to nearest, gives the next power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; operand captured on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbl_in | input | 64 | binary64 operand |
| rnd_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| sgl_out | output | 32 | binary32 result, registered |
| ovf_flag | output | 1 | Overflow of the single range |
| unf_flag | output | 1 | Tiny and inexact result |
| inx_flag | output | 1 | Result differs from the operand |

## Verification
The hardest situations to reach from the ports are those where a subnormal result is pushed up across the normal boundary by rounding, and exact ties at the subnormal scale. There the guard position moves with the exponent, so random fractions almost never land on them. The stimulus builds these operands directly. Examples are an exponent just below 2^-126 with an all-ones fraction, and exponents that place a lone leading 1 exactly on the guard bit (2^-150, 1.5 x 2^-150), each run under all four modes. A biased random sweep then concentrates exponents between the deep subnormal region and the overflow edge and plants ties at the normal guard position, and a behavioural remainder-comparison model checks every cycle.

// File: rtl/d2s_pkg.sv
package d2s_pkg;

    // operand and result formats
    localparam int DW = 64;
    localparam int DE = 11;
    localparam int DF = DW - DE - 1;
    localparam int SW = 32;
    localparam int SE = 8;
    localparam int SF = SW - SE - 1;

    // exponent arithmetic
    localparam int DBIAS    = (1 << (DE - 1)) - 1;
    localparam int SBIAS    = (1 << (SE - 1)) - 1;
    localparam int REBIAS   = DBIAS - SBIAS;
    localparam int SEXP_MAX = (1 << SE) - 1;

    // alignment window: hidden bit, fraction, zero padding
    localparam int ALIGN_W = DW;
    localparam int GRD_POS = ALIGN_W - 2 - SF;
    localparam int SH_MAX  = DF + 3;
    localparam int SH_W    = $clog2(SH_MAX + 1);

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_UP   = 2'b10,
        RM_DOWN = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_TINY = 3'd1,
        CL_FIN  = 3'd2,
        CL_INF  = 3'd3,
        CL_NAN  = 3'd4
    } opclass_e;

    typedef struct packed {
        logic          sign;
        opclass_e      cls;
        logic [DE-1:0] exp;
        logic [DF-1:0] frac;
    } dec_t;

endpackage

// File: rtl/d2s_classify.sv
module d2s_classify
    import d2s_pkg::*;
(
    input  logic [DW-1:0] op,
    output dec_t          dec
);

    logic          s;
    logic [DE-1:0] e;
    logic [DF-1:0] f;

    always_comb begin
        s = op[DW-1];
        e = op[DW-2 -: DE];
        f = op[DF-1:0];
        dec.sign = s;
        dec.exp  = e;
        dec.frac = f;
        if (&e) begin
            dec.cls = (f == '0) ? CL_INF : CL_NAN;
        end else if (e == '0) begin
            dec.cls = (f == '0) ? CL_ZERO : CL_TINY;
        end else begin
            dec.cls = CL_FIN;
        end
    end

endmodule

// File: rtl/d2s_align.sv
module d2s_align
    import d2s_pkg::*;
(
    input  logic [DE-1:0] exp_in,
    input  logic [DF-1:0] frac_in,
    input  logic          force_tiny,
    output logic [SE-1:0] exp_base,
    output logic [SF:0]   sig_keep,
    output logic          guard,
    output logic          sticky,
    output logic          tiny,
    output logic          huge
);

    localparam int TW  = DE + 2;
    localparam int PAD = ALIGN_W - 1 - DF;
    localparam logic signed [TW-1:0] REB_S  = TW'(REBIAS);
    localparam logic signed [TW-1:0] EMAX_S = TW'(SEXP_MAX);
    localparam logic signed [TW-1:0] ZERO_S = '0;
    localparam logic signed [TW-1:0] ONE_S  = TW'(1);
    localparam logic signed [TW-1:0] SHM_S  = TW'(SH_MAX);

    logic signed [TW-1:0]  t_exp;
    logic signed [TW-1:0]  nsh;
    logic [SH_W-1:0]       sh;
    logic [ALIGN_W-1:0]    wide;
    logic [ALIGN_W-1:0]    shifted;
    logic [ALIGN_W-1:0]    lost_mask;
    logic                  lost;

    always_comb begin
        t_exp = $signed({2'b00, exp_in}) - REB_S;
        tiny  = force_tiny || (t_exp <= ZERO_S);
        huge  = !force_tiny && (t_exp >= EMAX_S);
        nsh   = ONE_S - t_exp;

        if (force_tiny) begin
            sh = SH_W'(SH_MAX);
        end else if (!tiny) begin
            sh = '0;
        end else if (nsh > SHM_S) begin
            sh = SH_W'(SH_MAX);
        end else begin
            sh = nsh[SH_W-1:0];
        end

        wide      = {1'b1, frac_in, {PAD{1'b0}}};
        shifted   = wide >> sh;
        lost_mask = (ALIGN_W'(1) << sh) - ALIGN_W'(1);
        lost      = |(wide & lost_mask);

        sig_keep = shifted[ALIGN_W-1 -: SF+1];
        guard    = shifted[GRD_POS];
        sticky   = (|shifted[GRD_POS-1:0]) | lost;
        exp_base = tiny ? '0 : (t_exp[SE-1:0] - SE'(1));
    end

endmodule

// File: rtl/d2s_round.sv
module d2s_round
    import d2s_pkg::*;
(
    input  logic          sign,
    input  rmode_e        mode,
    input  logic [SE-1:0] exp_base,
    input  logic [SF:0]   sig_keep,
    input  logic          guard,
    input  logic          sticky,
    input  logic          huge,
    output logic [SW-2:0] mag,
    output logic          ovf,
    output logic          inx
);

    localparam logic [SW-2:0] INF_MAG = {{SE{1'b1}}, {SF{1'b0}}};
    localparam logic [SW-2:0] MAX_MAG = {{(SE-1){1'b1}}, 1'b0, {SF{1'b1}}};

    logic          up;
    logic          away;
    logic          lost_any;
    logic [SW-2:0] sum;

    always_comb begin
        lost_any = guard | sticky;
        unique case (mode)
            RM_NEAR: up = guard & (sticky | sig_keep[0]);
            RM_ZERO: up = 1'b0;
            RM_UP:   up = lost_any & !sign;
            RM_DOWN: up = lost_any & sign;
            default: up = 1'b0;
        endcase

        // carry out of the fraction flows straight into the exponent field
        sum = {exp_base, {SF{1'b0}}} + (SW-1)'(sig_keep) + (SW-1)'(up);

        away = (mode == RM_NEAR) || (mode == RM_UP && !sign) || (mode == RM_DOWN && sign);
        ovf  = huge | (&sum[SW-2 -: SE]);
        inx  = lost_any | ovf;

        if (ovf) begin
            mag = away ? INF_MAG : MAX_MAG;
        end else begin
            mag = sum;
        end
    end

endmodule

// File: rtl/d2s_converter.sv
module d2s_converter
    import d2s_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] dbl_in,
    input  logic [1:0]    rnd_mode,
    output logic [SW-1:0] sgl_out,
    output logic          ovf_flag,
    output logic          unf_flag,
    output logic          inx_flag
);

    dec_t          dec;
    logic [SE-1:0] exp_base;
    logic [SF:0]   sig_keep;
    logic          guard;
    logic          sticky;
    logic          tiny;
    logic          huge;
    logic [SW-2:0] mag;
    logic          r_ovf;
    logic          r_inx;
    logic          force_tiny;
    rmode_e        mode;

    logic [SW-1:0] nxt_out;
    logic          nxt_ovf;
    logic          nxt_unf;
    logic          nxt_inx;

    assign mode       = rmode_e'(rnd_mode);
    assign force_tiny = (dec.cls == CL_TINY);

    d2s_classify u_cls (
        .op  (dbl_in),
        .dec (dec)
    );

    d2s_align u_aln (
        .exp_in     (dec.exp),
        .frac_in    (dec.frac),
        .force_tiny (force_tiny),
        .exp_base   (exp_base),
        .sig_keep   (sig_keep),
        .guard      (guard),
        .sticky     (sticky),
        .tiny       (tiny),
        .huge       (huge)
    );

    d2s_round u_rnd (
        .sign     (dec.sign),
        .mode     (mode),
        .exp_base (exp_base),
        .sig_keep (sig_keep),
        .guard    (guard),
        .sticky   (sticky),
        .huge     (huge),
        .mag      (mag),
        .ovf      (r_ovf),
        .inx      (r_inx)
    );

    // result path selection by operand class
    always_comb begin
        nxt_out = '0;
        nxt_ovf = 1'b0;
        nxt_unf = 1'b0;
        nxt_inx = 1'b0;
        unique case (dec.cls)
            CL_ZERO: nxt_out = {dec.sign, {(SW-1){1'b0}}};
            CL_INF:  nxt_out = {dec.sign, {SE{1'b1}}, {SF{1'b0}}};
            CL_NAN:  nxt_out = {dec.sign, {SE{1'b1}}, 1'b1, dec.frac[DF-1 -: SF-1]};
            CL_TINY, CL_FIN: begin
                nxt_out = {dec.sign, mag};
                nxt_ovf = r_ovf;
                nxt_unf = tiny & r_inx;
                nxt_inx = r_inx;
            end
            default: nxt_out = '0;
        endcase
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sgl_out  <= '0;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
            inx_flag <= 1'b0;
        end else begin
            sgl_out  <= nxt_out;
            ovf_flag <= nxt_ovf;
            unf_flag <= nxt_unf;
            inx_flag <= nxt_inx;
        end
    end

endmodule

// File: rtl/d2s_converter_chk.sv
module d2s_converter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] dbl_in,
    input logic [1:0]  rnd_mode,
    input logic [31:0] sgl_out,
    input logic        ovf_flag,
    input logic        unf_flag,
    input logic        inx_flag
);

    p_ovf_implies_inx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> inx_flag);

    p_ovf_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (sgl_out[30:0] == 31'h7F800000 || sgl_out[30:0] == 31'h7F7FFFFF));

    p_unf_implies_inx_r11: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> inx_flag);

    p_unf_small_exp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> (sgl_out[30:23] <= 8'd1));

    p_nan_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sgl_out[30:23] == 8'hFF && sgl_out[22:0] != 23'h0) |-> sgl_out[22]);

    p_special_noflags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(&dbl_in[62:52]) |-> (!ovf_flag && !unf_flag && !inx_flag));

    p_zero_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dbl_in[62:0]) == 63'h0) |-> (sgl_out[30:0] == 31'h0 && !inx_flag));

    p_rtz_no_inf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rnd_mode) == 2'b01 && !$past(&dbl_in[62:52])) |-> (sgl_out[30:23] != 8'hFF));

endmodule

bind d2s_converter d2s_converter_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbl_in   (dbl_in),
    .rnd_mode (rnd_mode),
    .sgl_out  (sgl_out),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag),
    .inx_flag (inx_flag)
);

// File: tb/d2s_converter_tb_top.sv
module d2s_converter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] dbl_in;
    logic [1:0]  rnd_mode;
    logic [31:0] sgl_out;
    logic        ovf_flag;
    logic        unf_flag;
    logic        inx_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [34:0] pend;
    logic [63:0] pend_in;
    logic [1:0]  pend_mode;
    string       pend_tag;
    bit          have = 0;

    always #10 clk = ~clk;

    d2s_converter dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbl_in   (dbl_in),
        .rnd_mode (rnd_mode),
        .sgl_out  (sgl_out),
        .ovf_flag (ovf_flag),
        .unf_flag (unf_flag),
        .inx_flag (inx_flag)
    );

    // behavioural model: integer significand, remainder compared against half a unit
    function automatic logic [34:0] ref_conv(input logic [63:0] d, input logic [1:0] m);
        logic s;
        int e, t, r;
        logic [51:0] f;
        longint unsigned big_m, k, rem, half;
        bit exact, above, tie, up, away, ovf, unf;
        logic [31:0] bits;
        s = d[63];
        e = int'(d[62:52]);
        f = d[51:0];
        if (e == 2047) return (f == 0) ? {3'b000, s, 8'hFF, 23'h0} : {3'b000, s, 8'hFF, 1'b1, f[51:30]};
        if (e == 0 && f == 0) return {3'b000, s, 31'h0};
        big_m = (e == 0) ? {12'h0, f} : {11'h0, 1'b1, f};
        t = ((e == 0) ? 1 : e) - 896;
        r = (t >= 1) ? 29 : 30 - t;
        if (r >= 64) begin
            k = 0; exact = 0; above = 0; tie = 0;
        end else begin
            k = big_m >> r;
            rem = big_m & ((64'd1 << r) - 1);
            half = 64'd1 << (r - 1);
            exact = (rem == 0);
            above = (rem > half);
            tie = (rem == half);
        end
        case (m)
            2'd0: up = above || (tie && k[0]);
            2'd1: up = 0;
            2'd2: up = !exact && !s;
            default: up = !exact && s;
        endcase
        k = k + longint'(up);
        unf = (t <= 0) && !exact;
        ovf = 0;
        if (t >= 1) begin
            if (k == (64'd1 << 24)) begin
                k = 64'd1 << 23;
                t = t + 1;
            end
            if (t >= 255) begin
                ovf = 1;
                away = (m == 0) || (m == 2 && !s) || (m == 3 && s);
                bits = {s, away ? 31'h7F800000 : 31'h7F7FFFFF};
            end else begin
                bits = {s, t[7:0], k[22:0]};
            end
        end else begin
            bits = {s, k[30:0]};
        end
        return {ovf, unf, (!exact || ovf), bits};
    endfunction

    function automatic string auto_tag(input logic [63:0] d, input logic [1:0] m);
        int e, t;
        e = int'(d[62:52]);
        t = e - 896;
        if (e == 2047) return (d[51:0] == 0) ? "R5" : "R6";
        if (e == 0) return "R4";
        if (t >= 255) return "R7";
        if (t <= 0) return "R3";
        if (m != 2'd0) return "R9";
        return "R2";
    endfunction

    task automatic check_out();
        string ft;
        if (!have) return;
        checks++;
        if (sgl_out !== pend[31:0]) begin
            errors++;
            $display("FAIL %s result in=%h mode=%0d actual=%h expected=%h",
                     pend_tag, pend_in, pend_mode, sgl_out, pend[31:0]);
        end
        ft = pend[34] ? "R7" : (pend[33] ? "R11" : "R10");
        checks++;
        if ({ovf_flag, unf_flag, inx_flag} !== pend[34:32]) begin
            errors++;
            $display("FAIL %s flags(ovf,unf,inx) in=%h mode=%0d actual=%b expected=%b",
                     ft, pend_in, pend_mode, {ovf_flag, unf_flag, inx_flag}, pend[34:32]);
        end
    endtask

    task automatic apply(input logic [63:0] d, input logic [1:0] m, input string tag);
        @(negedge clk);
        check_out();
        dbl_in   = d;
        rnd_mode = m;
        pend     = ref_conv(d, m);
        pend_in  = d;
        pend_mode = m;
        pend_tag = (tag == "") ? auto_tag(d, m) : tag;
        have     = 1;
    endtask

    task automatic flush();
        @(negedge clk);
        check_out();
        have = 0;
    endtask

    logic [63:0] vec [24];
    string       vtag [24];

    initial begin
        vec[0]  = 64'h3FF0000000000000; vtag[0]  = "R2";
        vec[1]  = 64'h3FF0000010000000; vtag[1]  = "R8";
        vec[2]  = 64'h3FF0000030000000; vtag[2]  = "R8";
        vec[3]  = 64'hBFF0000008000001; vtag[3]  = "R9";
        vec[4]  = 64'h3FFFFFFFF0000000; vtag[4]  = "R12";
        vec[5]  = 64'h47EFFFFFE0000000; vtag[5]  = "R2";
        vec[6]  = 64'h47EFFFFFF0000000; vtag[6]  = "R7";
        vec[7]  = 64'hFFEFFFFFFFFFFFFF; vtag[7]  = "R7";
        vec[8]  = 64'h36A0000000000000; vtag[8]  = "R3";
        vec[9]  = 64'h3690000000000000; vtag[9]  = "R8";
        vec[10] = 64'hB698000000000000; vtag[10] = "R3";
        vec[11] = 64'h380FFFFFFFFFFFFF; vtag[11] = "R3";
        vec[12] = 64'h0000000000000001; vtag[12] = "R4";
        vec[13] = 64'h800FFFFFFFFFFFFF; vtag[13] = "R4";
        vec[14] = 64'h0000000000000000; vtag[14] = "R4";
        vec[15] = 64'h8000000000000000; vtag[15] = "R4";
        vec[16] = 64'h7FF0000000000000; vtag[16] = "R5";
        vec[17] = 64'hFFF0000000000000; vtag[17] = "R5";
        vec[18] = 64'h7FF0000000000001; vtag[18] = "R6";
        vec[19] = 64'hFFFABCDEF0123456; vtag[19] = "R6";
        vec[20] = 64'h3810000000000000; vtag[20] = "R2";
        vec[21] = 64'h3800000000000000; vtag[21] = "R3";
        vec[22] = 64'hC00FFFFFF8000000; vtag[22] = "R12";
        vec[23] = 64'h3FF0000008000000; vtag[23] = "R10";
    end

    initial begin
        rst_n    = 1'b0;
        dbl_in   = 64'h3FF0000000000000;
        rnd_mode = 2'b00;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset even with a live operand
        checks++;
        if ({sgl_out, ovf_flag, unf_flag, inx_flag} !== 35'h0) begin
            errors++;
            $display("FAIL R1 reset state actual=%h expected=%h",
                     {sgl_out, ovf_flag, unf_flag, inx_flag}, 35'h0);
        end
        rst_n = 1'b1;
        // R1: one-cycle latency on the first operand after reset
        apply(64'h4000000000000000, 2'b00, "R1");
        apply(64'hC000000000000000, 2'b01, "R1");

        for (int i = 0; i < 24; i++) begin
            for (int m = 0; m < 4; m++) begin
                apply(vec[i], 2'(m), vtag[i]);
            end
        end

        for (int n = 0; n < 6000; n++) begin
            logic [63:0] d;
            logic [10:0] e;
            d = {$urandom, $urandom};
            if (n % 4 != 3) begin
                e = 11'(850 + $urandom_range(0, 330));
                d[62:52] = e;
            end
            if ($urandom_range(0, 3) == 0) d[28:0] = 29'h10000000;
            apply(d, 2'($urandom_range(0, 3)), "");
        end
        flush();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule